// File: doc/BRIEF.md
# Transceiver Power Mode Sequencer

This block steps a radio transceiver through its power modes: Off, a power-up settle phase, Idle, Hibernate, Doze, and the Receive and Transmit paths with their warm-up phases. It runs from an always-on tick and takes a reset pin, an active-low attention pin, mode commands from the register port, an operation-finished strobe from the radio, and a compare value for a free-running wake timer. From the current mode it drives the oscillator enable, the reference clock output enable, the serial-port enable, the receiver and transmitter enables, and a drive enable for the digital pads.

Every settle and warm-up phase is a parameterised count of ticks. A phase always ends in Idle or in an active radio mode, and no enable of the next mode is asserted until its count has run out. Hibernate and Doze turn off the serial port, so these two modes can only be left through the attention pin or, in Doze, through a match of the wake timer.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low the mode is Off (code 0) and `osc_en`, `clko_en`, `spi_en`, `rx_en`, `tx_en` and `pad_oe` are all 0, so the pads are high impedance.
- R2: In the first clock after `rst_n` rises the mode moves to Settle (code 1). After `PWRUP_TICKS` cycles in Settle it moves to Idle (code 2).
- R3: In Idle `osc_en`, `clko_en`, `spi_en` and `pad_oe` are 1, and `rx_en` and `tx_en` are 0.
- R4: A command (`cmd_valid` with `cmd_op` 1 = Hibernate, 2 = Doze, 3 = Receive, 4 = Transmit) takes effect on the next clock only in Idle. Commands in any other mode, and codes 0, 5, 6 and 7 in Idle, leave the mode unchanged.
- R5: Hibernate (code 3) drives `osc_en`, `clko_en` and `spi_en` to 0. Only `attn_n` low leaves it: the mode goes to Settle for `HIB_TICKS` cycles and then to Idle.
- R6: Doze (code 4) keeps `osc_en` at 1 and `spi_en` at 0. When `attn_n` is low or the wake timer matches, the mode goes to Settle for `DOZE_TICKS` cycles and then to Idle.
- R7: In Doze `clko_en` equals `clko_cfg` AND (`clko_sel` >= `LOWRATE_SEL`). A divider select at or above this threshold gives an output rate of 1 MHz or lower.
- R8: A Receive command passes through Receive warm-up (code 5) for `WARM_TICKS` cycles and then enters Receive (code 6), where `rx_en` is 1. A Transmit command does the same through codes 7 and 8, with `tx_en` set to 1. `rx_en` and `tx_en` are 0 in every other mode.
- R9: `op_done` high during a warm-up or an active radio mode returns the mode to Idle on the next clock.
- R10: The wake timer is zero while in reset and counts up by one every clock, wrapping at 2^`TMR_W`. It matches when its value equals `wake_cmp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on tick clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| attn_n | input | 1 | Attention wake pin, active low |
| cmd_valid | input | 1 | Command strobe from the register port |
| cmd_op | input | 3 | Command code |
| op_done | input | 1 | Radio operation finished or aborted |
| wake_cmp | input | TMR_W | Wake timer compare value |
| clko_cfg | input | 1 | Allows the reference clock output in Doze |
| clko_sel | input | SEL_W | Reference clock output divider select |
| mode | output | 4 | Current mode code |
| osc_en | output | 1 | Oscillator enable |
| clko_en | output | 1 | Reference clock output enable |
| spi_en | output | 1 | Serial port enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| pad_oe | output | 1 | Digital pad drive enable |

## Verification
The bench builds the block with PWRUP_TICKS=5, HIB_TICKS=4, DOZE_TICKS=3, WARM_TICKS=6 and a 6-bit wake timer. These short counts make every settle boundary, and a full timer wrap, take only tens of cycles. With a 3-bit divider select and a threshold of 4, both sides of the Doze clock-output rule can be reached. A behavioural model steps alongside the design and compares all outputs on every clock, including the exact cycle in which a timer match ends a Doze.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [3:0] {
      M_OFF     = 4'd0,
      M_SETTLE  = 4'd1,
      M_IDLE    = 4'd2,
      M_HIB     = 4'd3,
      M_DOZE    = 4'd4,
      M_RXWARM  = 4'd5,
      M_RX      = 4'd6,
      M_TXWARM  = 4'd7,
      M_TX      = 4'd8
   } pmode_t;

   localparam logic [2:0] OP_HIB  = 3'd1;
   localparam logic [2:0] OP_DOZE = 3'd2;
   localparam logic [2:0] OP_RX   = 3'd3;
   localparam logic [2:0] OP_TX   = 3'd4;
endpackage

// File: rtl/pms_settle_cnt.sv
module pms_settle_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // the count never rises except on a load
   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pms_wake_timer.sv
module pms_wake_timer #(
   parameter int TMR_W  = 16,
   parameter bit HAS_TMR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] cmp,
   output logic             hit
);
   if (TMR_W < 2) begin : g_bad_w
      $error("pms_wake_timer: TMR_W must be at least 2");
   end

   if (HAS_TMR) begin : g_tmr
      logic [TMR_W-1:0] tmr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tmr_q <= '0;
         else        tmr_q <= tmr_q + 1'b1;
      end
      assign hit = (tmr_q == cmp);

      p_tmr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_q != '0 |-> tmr_q == $past(tmr_q) + 1'b1);
   end else begin : g_no_tmr
      assign hit = 1'b0;
   end
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int PWRUP_TICKS = 1000,
   parameter int HIB_TICKS   = 700,
   parameter int DOZE_TICKS  = 30,
   parameter int WARM_TICKS  = 144
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   attn_n,
   input  logic   cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic   op_done,
   input  logic   tmr_hit,
   output pmode_t state
);
   localparam int MAX_A = (PWRUP_TICKS > HIB_TICKS) ? PWRUP_TICKS : HIB_TICKS;
   localparam int MAX_B = (DOZE_TICKS > WARM_TICKS) ? DOZE_TICKS : WARM_TICKS;
   localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int DW    = $clog2(MAXD + 1);

   if (PWRUP_TICKS < 1 || HIB_TICKS < 1 || DOZE_TICKS < 1 || WARM_TICKS < 1) begin : g_bad_dly
      $error("pms_mode_fsm: every delay must be at least one tick");
   end

   pmode_t          state_q, state_d;
   logic            ld;
   logic [DW-1:0]   ld_val;
   logic            cnt_done;

   pms_settle_cnt #(.W(DW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .done     (cnt_done)
   );

   always_comb begin
      state_d = state_q;
      ld      = 1'b0;
      ld_val  = '0;
      unique case (state_q)
         M_OFF: begin
            state_d = M_SETTLE;
            ld      = 1'b1;
            ld_val  = DW'(PWRUP_TICKS - 1);
         end
         M_SETTLE: if (cnt_done) state_d = M_IDLE;
         M_IDLE: if (cmd_valid) begin
            case (cmd_op)
               OP_HIB:  state_d = M_HIB;
               OP_DOZE: state_d = M_DOZE;
               OP_RX: begin
                  state_d = M_RXWARM;
                  ld      = 1'b1;
                  ld_val  = DW'(WARM_TICKS - 1);
               end
               OP_TX: begin
                  state_d = M_TXWARM;
                  ld      = 1'b1;
                  ld_val  = DW'(WARM_TICKS - 1);
               end
               default: state_d = M_IDLE;
            endcase
         end
         M_HIB: if (!attn_n) begin
            state_d = M_SETTLE;
            ld      = 1'b1;
            ld_val  = DW'(HIB_TICKS - 1);
         end
         M_DOZE: if (!attn_n || tmr_hit) begin
            state_d = M_SETTLE;
            ld      = 1'b1;
            ld_val  = DW'(DOZE_TICKS - 1);
         end
         M_RXWARM: begin
            if (op_done)       state_d = M_IDLE;
            else if (cnt_done) state_d = M_RX;
         end
         M_TXWARM: begin
            if (op_done)       state_d = M_IDLE;
            else if (cnt_done) state_d = M_TX;
         end
         M_RX, M_TX: if (op_done) state_d = M_IDLE;
         default: state_d = M_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= M_OFF;
      else        state_q <= state_d;
   end

   assign state = state_q;

   p_hib_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == M_HIB && attn_n |=> state_q == M_HIB);
   p_rx_via_warm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == M_RX |-> $past(state_q) == M_RXWARM || $past(state_q) == M_RX);
   p_tx_via_warm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == M_TX |-> $past(state_q) == M_TXWARM || $past(state_q) == M_TX);
   p_done_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == M_RX || state_q == M_TX) && op_done |=> state_q == M_IDLE);
   p_cmd_doze_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == M_DOZE && attn_n && !tmr_hit |=> state_q == M_DOZE);
endmodule

// File: rtl/pms_out_decode.sv
module pms_out_decode
   import pwr_mode_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int LOWRATE_SEL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pmode_t           state,
   input  logic             clko_cfg,
   input  logic [SEL_W-1:0] clko_sel,
   output logic             osc_en,
   output logic             clko_en,
   output logic             spi_en,
   output logic             rx_en,
   output logic             tx_en,
   output logic             pad_oe
);
   if (LOWRATE_SEL < 0 || LOWRATE_SEL >= (1 << SEL_W)) begin : g_bad_sel
      $error("pms_out_decode: LOWRATE_SEL outside the select range");
   end

   logic slow_rate;
   assign slow_rate = (int'(clko_sel) >= LOWRATE_SEL);

   always_comb begin
      osc_en  = 1'b0;
      clko_en = 1'b0;
      spi_en  = 1'b0;
      rx_en   = 1'b0;
      tx_en   = 1'b0;
      pad_oe  = 1'b1;
      unique case (state)
         M_OFF:    pad_oe = 1'b0;
         M_SETTLE: osc_en = 1'b1;
         M_HIB:    ;
         M_DOZE: begin
            osc_en  = 1'b1;
            clko_en = clko_cfg & slow_rate;
         end
         M_IDLE, M_RXWARM, M_TXWARM, M_RX, M_TX: begin
            osc_en  = 1'b1;
            clko_en = 1'b1;
            spi_en  = 1'b1;
            rx_en   = (state == M_RX);
            tx_en   = (state == M_TX);
         end
         default: pad_oe = 1'b0;
      endcase
   end

   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      state == M_OFF |-> !pad_oe && !osc_en && !spi_en);
   p_sleep_spi_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state == M_HIB || state == M_DOZE |-> !spi_en && !rx_en && !tx_en);
   p_doze_clko_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state == M_DOZE && !clko_cfg |-> !clko_en);
   p_radio_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_en && tx_en));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int PWRUP_TICKS = 1000,
   parameter int HIB_TICKS   = 700,
   parameter int DOZE_TICKS  = 30,
   parameter int WARM_TICKS  = 144,
   parameter int TMR_W       = 16,
   parameter bit HAS_TMR     = 1'b1,
   parameter int SEL_W       = 3,
   parameter int LOWRATE_SEL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             attn_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic             op_done,
   input  logic [TMR_W-1:0] wake_cmp,
   input  logic             clko_cfg,
   input  logic [SEL_W-1:0] clko_sel,
   output logic [3:0]       mode,
   output logic             osc_en,
   output logic             clko_en,
   output logic             spi_en,
   output logic             rx_en,
   output logic             tx_en,
   output logic             pad_oe
);
   pmode_t state;
   logic   tmr_hit;

   pms_wake_timer #(.TMR_W(TMR_W), .HAS_TMR(HAS_TMR)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .cmp   (wake_cmp),
      .hit   (tmr_hit)
   );

   pms_mode_fsm #(
      .PWRUP_TICKS (PWRUP_TICKS),
      .HIB_TICKS   (HIB_TICKS),
      .DOZE_TICKS  (DOZE_TICKS),
      .WARM_TICKS  (WARM_TICKS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .attn_n    (attn_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .op_done   (op_done),
      .tmr_hit   (tmr_hit),
      .state     (state)
   );

   pms_out_decode #(.SEL_W(SEL_W), .LOWRATE_SEL(LOWRATE_SEL)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .clko_cfg (clko_cfg),
      .clko_sel (clko_sel),
      .osc_en   (osc_en),
      .clko_en  (clko_en),
      .spi_en   (spi_en),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .pad_oe   (pad_oe)
   );

   assign mode = state;

   p_idle_from_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state == M_IDLE |-> $past(state) inside {M_SETTLE, M_IDLE, M_RXWARM, M_RX, M_TXWARM, M_TX});
endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 5, HB = 4, DZ = 3, WM = 6, TW = 6, SW = 3, LOW = 4;
   localparam int TMOD = 1 << TW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic attn_n = 1'b1, cmd_valid = 1'b0, op_done = 1'b0, clko_cfg = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [TW-1:0] wake_cmp = '1;
   logic [SW-1:0] clko_sel = '0;
   logic [3:0] mode;
   logic osc_en, clko_en, spi_en, rx_en, tx_en, pad_oe;

   int checks = 0, errors = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_seq #(
      .PWRUP_TICKS(PW), .HIB_TICKS(HB), .DOZE_TICKS(DZ), .WARM_TICKS(WM),
      .TMR_W(TW), .HAS_TMR(1'b1), .SEL_W(SW), .LOWRATE_SEL(LOW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .op_done(op_done), .wake_cmp(wake_cmp),
      .clko_cfg(clko_cfg), .clko_sel(clko_sel), .mode(mode),
      .osc_en(osc_en), .clko_en(clko_en), .spi_en(spi_en),
      .rx_en(rx_en), .tx_en(tx_en), .pad_oe(pad_oe)
   );

   // behavioural reference model
   int m_mode = 0, m_cnt = 0, m_tmr = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode <= 0; m_cnt <= 0; m_tmr <= 0;
      end else begin
         m_tmr <= (m_tmr + 1) % TMOD;
         case (m_mode)
            0: begin m_mode <= 1; m_cnt <= PW - 1; end
            1: if (m_cnt == 0) m_mode <= 2; else m_cnt <= m_cnt - 1;
            2: if (cmd_valid) begin
                  if (cmd_op == 3'd1) m_mode <= 3;
                  else if (cmd_op == 3'd2) m_mode <= 4;
                  else if (cmd_op == 3'd3) begin m_mode <= 5; m_cnt <= WM - 1; end
                  else if (cmd_op == 3'd4) begin m_mode <= 7; m_cnt <= WM - 1; end
               end
            3: if (!attn_n) begin m_mode <= 1; m_cnt <= HB - 1; end
            4: if (!attn_n || m_tmr == int'(wake_cmp)) begin m_mode <= 1; m_cnt <= DZ - 1; end
            5, 7: if (op_done) m_mode <= 2;
                  else if (m_cnt == 0) m_mode <= m_mode + 1;
                  else m_cnt <= m_cnt - 1;
            6, 8: if (op_done) m_mode <= 2;
            default: m_mode <= 0;
         endcase
      end
   end

   function automatic string tag_of(int md);
      case (md)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R5";
         4: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (!done_flag) begin
         automatic int e_osc = (m_mode != 0 && m_mode != 3) ? 1 : 0;
         automatic int e_spi = (m_mode == 2 || m_mode >= 5) ? 1 : 0;
         automatic int e_clk = (m_mode == 2 || m_mode >= 5) ? 1 :
                               (m_mode == 4 && clko_cfg && int'(clko_sel) >= LOW) ? 1 : 0;
         automatic string t = tag_of(m_mode);
         chk(int'(mode) == m_mode, t, int'(mode), m_mode);
         chk(int'(osc_en) == e_osc, t, int'(osc_en), e_osc);
         chk(int'(spi_en) == e_spi, t, int'(spi_en), e_spi);
         chk(int'(clko_en) == e_clk, (m_mode == 4) ? "R7" : t, int'(clko_en), e_clk);
         chk(int'(rx_en) == ((m_mode == 6) ? 1 : 0), "R8", int'(rx_en), (m_mode == 6) ? 1 : 0);
         chk(int'(tx_en) == ((m_mode == 8) ? 1 : 0), "R8", int'(tx_en), (m_mode == 8) ? 1 : 0);
         chk(int'(pad_oe) == ((m_mode != 0) ? 1 : 0), "R1", int'(pad_oe), (m_mode != 0) ? 1 : 0);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [2:0] op);
      @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
      @(negedge clk); cmd_valid = 1'b0; cmd_op = 3'd0;
   endtask

   task automatic finish_run();
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      cyc(3);
      chk(mode == 4'd0 && !pad_oe, "R1", int'(mode), 0);
      rst_n = 1'b1;
      cyc(PW + 1);
      chk(mode == 4'd2, "R2", int'(mode), 2);                      // R2 settle length
      chk(spi_en && osc_en && clko_en, "R3", int'(spi_en), 1);     // R3 idle enables

      send(3'd7); cyc(2);                                          // R4 unknown code
      chk(mode == 4'd2, "R4", int'(mode), 2);

      send(3'd3); cyc(WM);                                          // R8 receive
      chk(mode == 4'd6 && rx_en, "R8", int'(mode), 6);
      send(3'd4); cyc(1);                                           // R4 command in Receive
      chk(mode == 4'd6, "R4", int'(mode), 6);
      @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0;
      chk(mode == 4'd2, "R9", int'(mode), 2);

      send(3'd4); cyc(2);                                           // R9 abort in warm-up
      @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0;
      chk(mode == 4'd2 && !tx_en, "R9", int'(mode), 2);
      send(3'd4); cyc(WM + 1);
      chk(mode == 4'd8 && tx_en, "R8", int'(mode), 8);
      @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0;

      send(3'd1); cyc(3);                                           // R5 hibernate
      chk(mode == 4'd3 && !osc_en && !spi_en, "R5", int'(mode), 3);
      send(3'd2); cyc(2);                                           // R4 ignored in Hibernate
      chk(mode == 4'd3, "R4", int'(mode), 3);
      @(negedge clk); attn_n = 1'b0; @(negedge clk); attn_n = 1'b1;
      cyc(HB);
      chk(mode == 4'd2, "R5", int'(mode), 2);

      clko_cfg = 1'b1; clko_sel = 3'd5;                             // R7 slow rate
      send(3'd2); cyc(1);
      chk(mode == 4'd4 && clko_en && !spi_en, "R7", int'(clko_en), 1);
      clko_sel = 3'd2; cyc(1);
      chk(!clko_en, "R7", int'(clko_en), 0);
      clko_sel = 3'd4; clko_cfg = 1'b0; cyc(1);
      chk(!clko_en, "R7", int'(clko_en), 0);
      @(negedge clk); attn_n = 1'b0; @(negedge clk); attn_n = 1'b1;
      cyc(DZ);
      chk(mode == 4'd2, "R6", int'(mode), 2);

      wake_cmp = TW'((m_tmr + 20) % TMOD);                          // R10 timer wake
      send(3'd2); cyc(5);
      chk(mode == 4'd4, "R10", int'(mode), 4);
      cyc(20);
      chk(mode == 4'd1 || mode == 4'd2, "R10", int'(mode), 1);
      wake_cmp = '1;
      cyc(DZ + 2);

      send(3'd3); cyc(3);                                           // R1 reset mid-operation
      @(negedge clk); rst_n = 1'b0; cyc(1);
      chk(mode == 4'd0 && !pad_oe && !osc_en, "R1", int'(mode), 0);
      rst_n = 1'b1; cyc(PW + 2);
      chk(mode == 4'd2, "R2", int'(mode), 2);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end
endmodule